// File: doc/BRIEF.md
# Memory-Card Identification State Controller

This block is the card-side tracker for a removable memory card while the card is in its identification phase. It sits behind the command deserialiser and CRC checker. For each accepted command it receives one decoded event: the command index, a flag marking an application-specific command, the host's voltage information, the card's busy level and the chip-select level. It keeps the card's protocol state and its relative card address register. It also raises a one-cycle indication that the card would answer the command, and latches SPI operating mode.

The card wakes in the idle state. It negotiates voltage, goes through ready and identification, and ends in standby with a freshly generated non-zero address. A sleep command parks the card in an inactive state. That state is sticky: only a power-on reset releases it. Commands that reach the card during a short start-up window are dropped.

Top module: `card_ident_fsm`

## Requirements
- R1: After power-on reset (`por_n` low), `card_state` is 0 (idle), `rel_addr` is 0x0000, `resp_valid` is 0 and `spi_mode` is 0, whatever state the card held before.
- R2: A command strobe presented during the first 74 clock cycles after `por_n` is released is ignored: no state change and no response.
- R3: Command index 15 with `cmd_app`=0 moves the card to inactive (4) from any other state, with no response. An inactive card ignores every command, including index 0, until the next power-on reset.
- R4: Command index 0 with `cmd_app`=0 moves any non-inactive card to idle (0), clears `rel_addr` to 0x0000 and gives no response.
- R5: In idle, index 41 with `cmd_app`=1 behaves as follows. If `card_busy`=1 or `volt_given`=0, the card stays idle and responds. Otherwise, with `volt_ok`=1 it moves to ready (1) and responds; with `volt_ok`=0 it moves to inactive (4) without a response.
- R6: In ready, index 2 with `cmd_app`=0 moves the card to identification (2) and responds.
- R7: In identification or standby, index 3 with `cmd_app`=0 moves the card to standby (3) and responds. In the same cycle `rel_addr` is loaded with a new non-zero value that differs from the previous one.
- R8: Index 0 accepted while `cs_n`=0 sets `spi_mode` to 1. It then stays 1 until power-on reset. An index 0 with `cs_n`=1 leaves `spi_mode` unchanged.
- R9: A command that is not valid in the current state produces no response and leaves `card_state` and `rel_addr` unchanged.
- R10: State encoding is idle=0, ready=1, ident=2, stby=3, ina=4. Outputs change at the clock edge that samples `cmd_valid`, and `resp_valid` is high for exactly one cycle per responding command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| por_n | input | 1 | Power-on reset, active low |
| cmd_valid | input | 1 | One-cycle strobe: a decoded command is present |
| cmd_index | input | 6 | Command index |
| cmd_app | input | 1 | Command is an application-specific command |
| volt_given | input | 1 | Host supplied a voltage window |
| volt_ok | input | 1 | Host voltage window is compatible with the card |
| card_busy | input | 1 | Card power-up is still in progress |
| cs_n | input | 1 | Chip-select level sampled with the command |
| card_state | output | 3 | Current protocol state |
| rel_addr | output | 16 | Relative card address register |
| resp_valid | output | 1 | Card answers the command just taken |
| spi_mode | output | 1 | SPI operating mode latched |

## Verification
A wrong internal state shows at the ports one cycle after the next command strobe. It appears as a wrong `card_state` code, a missing or spurious `resp_valid` pulse, or a `rel_addr` that is zero or unchanged where a new address was due. An inactive state that leaks shows as soon as any command moves the card. An error in the start-up window shows as a response to a command given before the window has elapsed. A lost SPI latch appears on the `spi_mode` pin right after the reset command that should have set it.

// File: rtl/cid_pkg.sv
package cid_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_READY = 3'd1,
      ST_IDENT = 3'd2,
      ST_STBY  = 3'd3,
      ST_INA   = 3'd4
   } card_state_e;

   localparam int unsigned IDX_RESET  = 0;
   localparam int unsigned IDX_GETID  = 2;
   localparam int unsigned IDX_ADDR   = 3;
   localparam int unsigned IDX_SLEEP  = 15;
   localparam int unsigned IDX_OPCOND = 41;

   typedef struct packed {
      card_state_e nxt;
      logic        respond;
      logic        load_addr;
      logic        clr_addr;
      logic        set_spi;
   } cid_decision_t;

endpackage

// File: rtl/cid_wake_timer.sv
module cid_wake_timer #(
   parameter int unsigned WAKE_CYCLES = 74
) (
   input  logic clk,
   input  logic por_n,
   output logic awake
);
   localparam int unsigned CW = (WAKE_CYCLES < 2) ? 1 : $clog2(WAKE_CYCLES + 1);
   localparam logic [CW-1:0] LIMIT = CW'(WAKE_CYCLES);

   logic [CW-1:0] cnt_q;

   generate
      if (WAKE_CYCLES == 0) begin : g_none
         assign awake = 1'b1;
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) cnt_q <= '0;
            else        cnt_q <= '0;
         end
      end else begin : g_count
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n)              cnt_q <= '0;
            else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
         end
         assign awake = (cnt_q == LIMIT);
      end
   endgenerate
endmodule

// File: rtl/cid_addr_lfsr.sv
module cid_addr_lfsr #(
   parameter int unsigned     W    = 16,
   parameter logic [W-1:0]    TAPS = 16'hB400,
   parameter logic [W-1:0]    SEED = 16'hACE1
) (
   input  logic         clk,
   input  logic         por_n,
   output logic [W-1:0] value
);
   generate
      if (W < 2) begin : g_bad_w
         $error("cid_addr_lfsr: width must be at least 2");
      end
      if (SEED == '0) begin : g_bad_seed
         $error("cid_addr_lfsr: seed must be non-zero");
      end
      if (TAPS[W-1] != 1'b1) begin : g_bad_taps
         $error("cid_addr_lfsr: top tap must be set");
      end
   endgenerate

   logic [W-1:0] q;
   logic         fb;

   assign fb = ^(q & TAPS);

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) q <= SEED;
      else        q <= {q[W-2:0], fb};
   end

   assign value = q;
endmodule

// File: rtl/cid_decode.sv
module cid_decode
   import cid_pkg::*;
#(
   parameter int unsigned IDX_W = 6
) (
   input  card_state_e   cur,
   input  logic [IDX_W-1:0] idx,
   input  logic          app,
   input  logic          volt_given,
   input  logic          volt_ok,
   input  logic          busy,
   input  logic          cs_n,
   output cid_decision_t dec
);
   logic is_reset, is_sleep, is_getid, is_addr, is_opcond;

   assign is_reset  = !app && (idx == IDX_W'(IDX_RESET));
   assign is_sleep  = !app && (idx == IDX_W'(IDX_SLEEP));
   assign is_getid  = !app && (idx == IDX_W'(IDX_GETID));
   assign is_addr   = !app && (idx == IDX_W'(IDX_ADDR));
   assign is_opcond =  app && (idx == IDX_W'(IDX_OPCOND));

   always_comb begin
      dec.nxt       = cur;
      dec.respond   = 1'b0;
      dec.load_addr = 1'b0;
      dec.clr_addr  = 1'b0;
      dec.set_spi   = 1'b0;
      if (cur != ST_INA) begin
         if (is_reset) begin
            dec.nxt      = ST_IDLE;
            dec.clr_addr = 1'b1;
            dec.set_spi  = !cs_n;
         end else if (is_sleep) begin
            dec.nxt = ST_INA;
         end else begin
            unique case (cur)
               ST_IDLE: if (is_opcond) begin
                  if (busy || !volt_given) begin
                     dec.respond = 1'b1;
                  end else if (volt_ok) begin
                     dec.nxt     = ST_READY;
                     dec.respond = 1'b1;
                  end else begin
                     dec.nxt = ST_INA;
                  end
               end
               ST_READY: if (is_getid) begin
                  dec.nxt     = ST_IDENT;
                  dec.respond = 1'b1;
               end
               ST_IDENT, ST_STBY: if (is_addr) begin
                  dec.nxt       = ST_STBY;
                  dec.respond   = 1'b1;
                  dec.load_addr = 1'b1;
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/card_ident_fsm.sv
module card_ident_fsm
   import cid_pkg::*;
#(
   parameter int unsigned IDX_W       = 6,
   parameter int unsigned ADDR_W      = 16,
   parameter int unsigned WAKE_CYCLES = 74,
   parameter bit          SPI_EN      = 1'b1,
   parameter logic [ADDR_W-1:0] ADDR_TAPS = 16'hB400,
   parameter logic [ADDR_W-1:0] ADDR_SEED = 16'hACE1
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              cmd_valid,
   input  logic [IDX_W-1:0]  cmd_index,
   input  logic              cmd_app,
   input  logic              volt_given,
   input  logic              volt_ok,
   input  logic              card_busy,
   input  logic              cs_n,
   output logic [2:0]        card_state,
   output logic [ADDR_W-1:0] rel_addr,
   output logic              resp_valid,
   output logic              spi_mode
);
   generate
      if (IDX_W < 6) begin : g_bad_idx
         $error("card_ident_fsm: index width must hold 41");
      end
   endgenerate

   card_state_e   state_q;
   cid_decision_t dec;
   logic          awake;
   logic          take;
   logic [ADDR_W-1:0] gen_addr;
   logic [ADDR_W-1:0] addr_q;
   logic          resp_q;

   cid_wake_timer #(.WAKE_CYCLES(WAKE_CYCLES)) u_wake (
      .clk   (clk),
      .por_n (por_n),
      .awake (awake)
   );

   cid_addr_lfsr #(.W(ADDR_W), .TAPS(ADDR_TAPS), .SEED(ADDR_SEED)) u_addr (
      .clk   (clk),
      .por_n (por_n),
      .value (gen_addr)
   );

   cid_decode #(.IDX_W(IDX_W)) u_dec (
      .cur        (state_q),
      .idx        (cmd_index),
      .app        (cmd_app),
      .volt_given (volt_given),
      .volt_ok    (volt_ok),
      .busy       (card_busy),
      .cs_n       (cs_n),
      .dec        (dec)
   );

   assign take = cmd_valid && awake;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         state_q <= ST_IDLE;
         addr_q  <= '0;
         resp_q  <= 1'b0;
      end else begin
         resp_q <= take && dec.respond;
         if (take) begin
            state_q <= dec.nxt;
            if (dec.clr_addr)       addr_q <= '0;
            else if (dec.load_addr) addr_q <= gen_addr;
         end
      end
   end

   generate
      if (SPI_EN) begin : g_spi
         logic spi_q;
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n)                    spi_q <= 1'b0;
            else if (take && dec.set_spi)  spi_q <= 1'b1;
         end
         assign spi_mode = spi_q;
      end else begin : g_no_spi
         assign spi_mode = 1'b0;
      end
   endgenerate

   assign card_state = state_q;
   assign rel_addr   = addr_q;
   assign resp_valid = resp_q;
endmodule

// File: rtl/cid_checker.sv
module cid_checker #(
   parameter int unsigned ADDR_W = 16
) (
   input logic              clk,
   input logic              por_n,
   input logic              cmd_valid,
   input logic [2:0]        card_state,
   input logic [ADDR_W-1:0] rel_addr,
   input logic              resp_valid,
   input logic              spi_mode
);
   AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!por_n)
      card_state <= 3'd4);                                             // R10
   AST_INA_STICKY: assert property (@(posedge clk) disable iff (!por_n)
      card_state == 3'd4 |=> card_state == 3'd4);                      // R3
   AST_NO_RESP_WITHOUT_CMD: assert property (@(posedge clk) disable iff (!por_n)
      !cmd_valid |=> !resp_valid);                                     // R10
   AST_QUIET_WITHOUT_CMD: assert property (@(posedge clk) disable iff (!por_n)
      !cmd_valid |=> ($stable(card_state) && $stable(rel_addr)));      // R9
   AST_ADDR_NONZERO_STBY: assert property (@(posedge clk) disable iff (!por_n)
      card_state == 3'd3 |-> rel_addr != '0);                          // R7
   AST_ADDR_ZERO_EARLY: assert property (@(posedge clk) disable iff (!por_n)
      card_state <= 3'd2 |-> rel_addr == '0);                          // R4
   AST_SPI_STICKY: assert property (@(posedge clk) disable iff (!por_n)
      spi_mode |=> spi_mode);                                          // R8
endmodule

bind card_ident_fsm cid_checker #(.ADDR_W(ADDR_W)) u_cid_checker (
   .clk        (clk),
   .por_n      (por_n),
   .cmd_valid  (cmd_valid),
   .card_state (card_state),
   .rel_addr   (rel_addr),
   .resp_valid (resp_valid),
   .spi_mode   (spi_mode)
);

// File: tb/test_card_ident_fsm.sv
module test_card_ident_fsm;
   logic        clk = 1'b0;
   logic        por_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [5:0]  cmd_index = '0;
   logic        cmd_app = 1'b0;
   logic        volt_given = 1'b0;
   logic        volt_ok = 1'b0;
   logic        card_busy = 1'b0;
   logic        cs_n = 1'b1;
   logic [2:0]  card_state;
   logic [15:0] rel_addr;
   logic        resp_valid;
   logic        spi_mode;

   int n_cmp = 0;
   int n_bad = 0;
   logic [15:0] prev_addr;

   always #2 clk = ~clk;

   card_ident_fsm i_card_ident_fsm (
      .clk(clk), .por_n(por_n), .cmd_valid(cmd_valid), .cmd_index(cmd_index),
      .cmd_app(cmd_app), .volt_given(volt_given), .volt_ok(volt_ok),
      .card_busy(card_busy), .cs_n(cs_n), .card_state(card_state),
      .rel_addr(rel_addr), .resp_valid(resp_valid), .spi_mode(spi_mode)
   );

   // fields: index, app, volt_given, volt_ok, busy, cs_n, exp_state, exp_resp
   localparam int NV = 14;
   localparam logic [14:0] VEC [NV] = '{
      {6'd2,  1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 3'd0, 1'b0},  // R9 getid in idle
      {6'd41, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 3'd0, 1'b1},  // R5 busy
      {6'd41, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 3'd0, 1'b1},  // R5 no voltage
      {6'd41, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 3'd1, 1'b1},  // R5 compatible
      {6'd3,  1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 3'd1, 1'b0},  // R9 addr in ready
      {6'd2,  1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 3'd2, 1'b1},  // R6
      {6'd3,  1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 3'd3, 1'b1},  // R7
      {6'd3,  1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 3'd3, 1'b1},  // R7 again
      {6'd41, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 3'd3, 1'b0},  // R9 opcond in stby
      {6'd0,  1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 3'd0, 1'b0},  // R4
      {6'd41, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 3'd1, 1'b1},  // R5
      {6'd15, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 3'd4, 1'b0},  // R3
      {6'd0,  1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 3'd4, 1'b0},  // R3 reset ignored
      {6'd41, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 3'd4, 1'b0}   // R3 opcond ignored
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic issue(input logic [5:0] idx, input logic app, input logic vg,
                        input logic vo, input logic bz, input logic cs);
      @(negedge clk);
      cmd_index = idx; cmd_app = app; volt_given = vg; volt_ok = vo;
      card_busy = bz; cs_n = cs; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic power_on();
      @(negedge clk);
      por_n = 1'b0;
      repeat (3) @(negedge clk);
      por_n = 1'b1;
      repeat (80) @(negedge clk);
   endtask

   initial begin
      #400000;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 state", card_state, 0);
      check("R1 addr", rel_addr, 0);
      check("R1 resp", resp_valid, 0);
      check("R1 spi", spi_mode, 0);
      por_n = 1'b1;
      repeat (4) @(negedge clk);
      issue(6'd41, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
      check("R2 early state", card_state, 0);
      check("R2 early resp", resp_valid, 0);
      issue(6'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
      check("R2 early spi", spi_mode, 0);
      repeat (80) @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         issue(VEC[i][14:9], VEC[i][8], VEC[i][7], VEC[i][6], VEC[i][5], VEC[i][4]);
         check($sformatf("R10 vec %0d state", i), card_state, VEC[i][3:1]);
         check($sformatf("R10 vec %0d resp", i), resp_valid, VEC[i][0]);
         @(negedge clk);
         check($sformatf("R10 vec %0d pulse", i), resp_valid, 0);
      end
      check("R3 spi untouched in ina", spi_mode, 0);

      power_on();
      check("R1 state after ina", card_state, 0);
      issue(6'd41, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
      issue(6'd2, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
      check("R6 addr zero in ident", rel_addr, 0);
      issue(6'd3, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
      check("R7 state", card_state, 3);
      check("R7 addr nonzero", rel_addr != 16'd0, 1);
      prev_addr = rel_addr;
      repeat (5) @(negedge clk);
      issue(6'd3, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
      check("R7 addr changed", rel_addr != prev_addr, 1);
      check("R7 addr nonzero again", rel_addr != 16'd0, 1);
      prev_addr = rel_addr;
      issue(6'd2, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
      check("R9 addr kept", rel_addr, prev_addr);
      check("R9 state kept", card_state, 3);
      issue(6'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
      check("R4 addr cleared", rel_addr, 0);
      check("R8 spi not set by cs high", spi_mode, 0);
      issue(6'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
      check("R8 spi set", spi_mode, 1);
      issue(6'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
      check("R8 spi held", spi_mode, 1);
      issue(6'd41, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
      check("R5 incompatible state", card_state, 4);
      check("R5 incompatible resp", resp_valid, 0);
      power_on();
      check("R1 spi cleared", spi_mode, 0);
      issue(6'd41, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
      issue(6'd2, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
      issue(6'd15, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
      check("R3 sleep from ident", card_state, 4);
      check("R3 sleep no resp", resp_valid, 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule